// File: doc/BRIEF.md
# Backplane Time-Slot Assignment Port

This block joins four subscriber line channels to a shared time-division multiplexed backplane. Every line carries two byte-wide bearer channels (B1, B2) and one 2-bit-per-frame signalling channel (D). The bearer channels of all lines share one serial input/output pair. The signalling channels share a second pair. A frame sync pulse marks the start of each frame. The block counts serial bit positions from that pulse and compares them with per-line slot numbers written through a simple register-write port.

Toward the line side, the block collects the serial input bits that fall in each line's transmit slots into holding registers. Once per frame it presents the collected bytes on parallel per-line ports, together with a one-cycle strobe. From the line side, it takes parallel per-line receive data, freezes it at the start of each frame, and shifts it out MSB first during the assigned receive slots. Outside those slots the outputs are released. An active-low busy strobe marks every bearer receive slot that is driven.

The whole block runs on one system clock. The bit clock and the frame sync are sampled as ordinary synchronous inputs, so the system clock must be at least four times faster than the bit clock.

Top module: `tsa_backplane_port`

## Requirements
- R1: After reset every assignment register and every D-enable bit is zero. `bo_oe` and `do_oe` are low and `tsb_n` is high. `tx_b1`/`tx_b2` read 8'hFF, `tx_d` reads 2'b11 and `tx_stb` is low.
- R2: A rising bit-clock edge at which `fs` is high starts bit position 0, and every later rising edge adds one to the position. Byte slot = position/8, D sub-slot = position/2. A new `fs` restarts the count at any point.
- R3: When a receive B register has bit 7 set, the byte for that channel is driven on `bo` MSB first while the slot number in bits 5:0 is current, with `bo_oe` high. When no enabled receive B slot matches, `bo_oe` is low.
- R4: Register writes use `wr_sel` codes 0 tx-B1, 1 tx-B2, 2 tx-D sub-slot, 3 rx-B1, 4 rx-B2, 5 rx-D sub-slot and 6 D enables (bit 0 transmit, bit 1 receive). Code 7 is ignored. In B registers, bit 7 is the enable, bits 5:0 are the slot and bit 6 is ignored.
- R5: `tsb_n` is low exactly during bit positions in which an enabled receive B slot is driven on `bo`, and high otherwise.
- R6: With its receive D enable set, a line drives its 2-bit receive D value on `do_data` MSB first, with `do_oe` high, during the sub-slot held in its rx-D register.
- R7: `bi` is sampled on the falling bit-clock edge. Bits in an enabled transmit B slot are stored MSB first. At the next frame start they appear on `tx_b1`/`tx_b2`, and `tx_stb` pulses for exactly one clock.
- R8: At a frame start, a transmit B channel whose enable bit is clear presents 8'hFF. A line whose transmit D enable is clear presents 2'b11.
- R9: `di` bits in an enabled transmit D sub-slot are stored MSB first and presented on `tx_d` at the next frame start.
- R10: When several enabled receive channels claim the same slot, the lowest line drives. Within a line, B1 drives ahead of B2, and D channels follow the same line order.
- R11: Receive parallel data is captured at the frame start. Changes on `rx_b1`, `rx_b2` or `rx_d` during a frame do not reach `bo`/`do_data` until the next frame.
- R12: `bo`, `bo_oe`, `tsb_n`, `do_data` and `do_oe` change only in the clock that follows a detected rising bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock, sampled by clk |
| fs | input | 1 | Frame sync, sampled at rising bclk |
| bi | input | 1 | Serial bearer data toward the lines |
| di | input | 1 | Serial signalling data toward the lines |
| bo | output | 1 | Serial bearer data from the lines |
| bo_oe | output | 1 | Drive enable for bo |
| tsb_n | output | 1 | Active-low busy strobe for driven bearer slots |
| do_data | output | 1 | Serial signalling data from the lines |
| do_oe | output | 1 | Drive enable for do_data |
| wr_en | input | 1 | Register write strobe |
| wr_line | input | 2 | Line addressed by the write |
| wr_sel | input | 3 | Register selected within the line |
| wr_data | input | 8 | Write data |
| rx_b1 | input | 32 | Receive B1 bytes, line n at [8n+7:8n] |
| rx_b2 | input | 32 | Receive B2 bytes, line n at [8n+7:8n] |
| rx_d | input | 8 | Receive D pairs, line n at [2n+1:2n] |
| tx_b1 | output | 32 | Collected transmit B1 bytes per line |
| tx_b2 | output | 32 | Collected transmit B2 bytes per line |
| tx_d | output | 8 | Collected transmit D pairs per line |
| tx_stb | output | 1 | One-clock pulse when transmit ports update |

## Verification
Some properties are checked on every clock by assertions. The serial outputs hold still between rising bit-clock edges. `tsb_n` is never high while `bo` is driven. An output enable only rises after a rising edge. The transmit strobe is a single-clock pulse tied to a frame start. The bit position never moves without a rising edge.

Other behaviour can only be shown by the directed scenarios. These include slot decoding and MSB-first ordering, the ignored bit 6, and conflict priority. They also include freezing receive data at frame start, the all-ones value of disabled transmit channels, and re-alignment on an early frame sync. For these, a bench-side model predicts every bit position of whole frames.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  typedef enum logic [2:0] {
    SEL_TX_B1 = 3'd0,
    SEL_TX_B2 = 3'd1,
    SEL_TX_D  = 3'd2,
    SEL_RX_B1 = 3'd3,
    SEL_RX_B2 = 3'd4,
    SEL_RX_D  = 3'd5,
    SEL_D_EN  = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  localparam int BYTE_BITS = 8;   // bits per bearer slot
  localparam int SUB_BITS  = 2;   // bits per signalling sub-slot
  localparam int EN_BIT    = 7;   // enable position in a bearer register
endpackage

// File: rtl/tsa_regs.sv
module tsa_regs
  import tsa_pkg::*;
#(
  parameter int NL = 4,
  parameter int LW = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [LW-1:0]       wr_line,
  input  logic [2:0]          wr_sel,
  input  logic [7:0]          wr_data,
  output logic [NL-1:0][7:0]  txb1,
  output logic [NL-1:0][7:0]  txb2,
  output logic [NL-1:0][7:0]  txd,
  output logic [NL-1:0][7:0]  rxb1,
  output logic [NL-1:0][7:0]  rxb2,
  output logic [NL-1:0][7:0]  rxd,
  output logic [NL-1:0]       txd_en,
  output logic [NL-1:0]       rxd_en
);
  logic line_ok;
  assign line_ok = (int'(wr_line) < NL);

  always_ff @(posedge clk) begin
    if (rst) begin
      txb1 <= '0; txb2 <= '0; txd <= '0;
      rxb1 <= '0; rxb2 <= '0; rxd <= '0;
      txd_en <= '0; rxd_en <= '0;
    end else if (wr_en && line_ok) begin
      case (reg_sel_e'(wr_sel))
        SEL_TX_B1: txb1[wr_line] <= wr_data;
        SEL_TX_B2: txb2[wr_line] <= wr_data;
        SEL_TX_D:  txd[wr_line]  <= wr_data;
        SEL_RX_B1: rxb1[wr_line] <= wr_data;
        SEL_RX_B2: rxb2[wr_line] <= wr_data;
        SEL_RX_D:  rxd[wr_line]  <= wr_data;
        SEL_D_EN: begin
          txd_en[wr_line] <= wr_data[0];
          rxd_en[wr_line] <= wr_data[1];
        end
        default: ;
      endcase
    end
  end

  // R4: a write with the unused select code leaves every register unchanged
  assert_unused_sel_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 3'd7) |=> $stable({txb1, txb2, txd, rxb1, rxb2, rxd, txd_en, rxd_en}));
endmodule

// File: rtl/tsa_frame_cnt.sv
module tsa_frame_cnt #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk,
  input  logic             fs,
  output logic             rise,
  output logic             fall,
  output logic             frame_start,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] next_pos
);
  logic bclk_q;

  assign rise        = bclk & ~bclk_q;
  assign fall        = ~bclk & bclk_q;
  assign frame_start = rise & fs;
  assign next_pos    = fs ? '0 : pos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      pos    <= '0;
    end else begin
      bclk_q <= bclk;
      if (rise) pos <= next_pos;
    end
  end

  // R2: the bit position only moves on a rising bit-clock edge
  assert_pos_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(pos));
endmodule

// File: rtl/tsa_tx_capture.sv
module tsa_tx_capture
  import tsa_pkg::*;
#(
  parameter int NL     = 4,
  parameter int SLOT_W = 6,
  parameter int POS_W  = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fall,
  input  logic                       frame_start,
  input  logic [POS_W-1:0]           pos,
  input  logic                       bi,
  input  logic                       di,
  input  logic [NL-1:0][7:0]         txb1,
  input  logic [NL-1:0][7:0]         txb2,
  input  logic [NL-1:0][7:0]         txd,
  input  logic [NL-1:0]              txd_en,
  output logic [NL-1:0][BYTE_BITS-1:0] out_b1,
  output logic [NL-1:0][BYTE_BITS-1:0] out_b2,
  output logic [NL-1:0][SUB_BITS-1:0]  out_d,
  output logic                       stb
);
  localparam int SUB_W = POS_W - 1;

  logic [SLOT_W-1:0] cur_slot;
  logic [SUB_W-1:0]  cur_sub;
  logic [2:0]        bit_idx;
  logic              sub_idx;

  assign cur_slot = pos[POS_W-1:3];
  assign cur_sub  = pos[POS_W-1:1];
  assign bit_idx  = ~pos[2:0];
  assign sub_idx  = ~pos[0];

  for (genvar l = 0; l < NL; l++) begin : g_line
    logic [BYTE_BITS-1:0] hold_b1, hold_b2;
    logic [SUB_BITS-1:0]  hold_d;

    always_ff @(posedge clk) begin
      if (rst) begin
        hold_b1   <= '0;
        hold_b2   <= '0;
        hold_d    <= '0;
        out_b1[l] <= '1;
        out_b2[l] <= '1;
        out_d[l]  <= '1;
      end else begin
        if (fall) begin
          if (txb1[l][EN_BIT] && txb1[l][SLOT_W-1:0] == cur_slot) hold_b1[bit_idx] <= bi;
          if (txb2[l][EN_BIT] && txb2[l][SLOT_W-1:0] == cur_slot) hold_b2[bit_idx] <= bi;
          if (txd_en[l] && txd[l][SUB_W-1:0] == cur_sub) hold_d[sub_idx] <= di;
        end
        if (frame_start) begin
          out_b1[l] <= txb1[l][EN_BIT] ? hold_b1 : '1;
          out_b2[l] <= txb2[l][EN_BIT] ? hold_b2 : '1;
          out_d[l]  <= txd_en[l] ? hold_d : '1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stb <= 1'b0;
    else     stb <= frame_start;
  end

  // R7: the transmit strobe is a single clock wide
  assert_stb_single_R7: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);
  // R7: the transmit strobe follows a frame start
  assert_stb_source_R7: assert property (@(posedge clk) disable iff (rst)
    stb |-> $past(frame_start));
endmodule

// File: rtl/tsa_rx_drive.sv
module tsa_rx_drive
  import tsa_pkg::*;
#(
  parameter int NL     = 4,
  parameter int SLOT_W = 6,
  parameter int POS_W  = 9
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rise,
  input  logic                         frame_start,
  input  logic [POS_W-1:0]             next_pos,
  input  logic [NL-1:0][7:0]           rxb1,
  input  logic [NL-1:0][7:0]           rxb2,
  input  logic [NL-1:0][7:0]           rxd,
  input  logic [NL-1:0]                rxd_en,
  input  logic [NL-1:0][BYTE_BITS-1:0] in_b1,
  input  logic [NL-1:0][BYTE_BITS-1:0] in_b2,
  input  logic [NL-1:0][SUB_BITS-1:0]  in_d,
  output logic                         bo,
  output logic                         bo_oe,
  output logic                         tsb_n,
  output logic                         do_data,
  output logic                         do_oe
);
  localparam int SUB_W = POS_W - 1;

  logic [NL-1:0][BYTE_BITS-1:0] sh_b1, sh_b2, eff_b1, eff_b2;
  logic [NL-1:0][SUB_BITS-1:0]  sh_d, eff_d;
  logic [SLOT_W-1:0] n_slot;
  logic [SUB_W-1:0]  n_sub;
  logic [2:0]        n_bit;
  logic              n_sbit;
  logic              b_hit, b_val, d_hit, d_val;

  assign n_slot = next_pos[POS_W-1:3];
  assign n_sub  = next_pos[POS_W-1:1];
  assign n_bit  = ~next_pos[2:0];
  assign n_sbit = ~next_pos[0];

  // the frame-start edge must already see the new frame's data for bit 0
  assign eff_b1 = frame_start ? in_b1 : sh_b1;
  assign eff_b2 = frame_start ? in_b2 : sh_b2;
  assign eff_d  = frame_start ? in_d  : sh_d;

  // highest line scanned first so the lowest line, and B1 within it, wins
  always_comb begin
    b_hit = 1'b0; b_val = 1'b0; d_hit = 1'b0; d_val = 1'b0;
    for (int l = NL - 1; l >= 0; l--) begin
      if (rxb2[l][EN_BIT] && rxb2[l][SLOT_W-1:0] == n_slot) begin
        b_hit = 1'b1; b_val = eff_b2[l][n_bit];
      end
      if (rxb1[l][EN_BIT] && rxb1[l][SLOT_W-1:0] == n_slot) begin
        b_hit = 1'b1; b_val = eff_b1[l][n_bit];
      end
      if (rxd_en[l] && rxd[l][SUB_W-1:0] == n_sub) begin
        d_hit = 1'b1; d_val = eff_d[l][n_sbit];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_b1 <= '0; sh_b2 <= '0; sh_d <= '0;
      bo <= 1'b0; bo_oe <= 1'b0; tsb_n <= 1'b1;
      do_data <= 1'b0; do_oe <= 1'b0;
    end else begin
      if (frame_start) begin
        sh_b1 <= in_b1; sh_b2 <= in_b2; sh_d <= in_d;
      end
      if (rise) begin
        bo      <= b_hit & b_val;
        bo_oe   <= b_hit;
        tsb_n   <= ~b_hit;
        do_data <= d_hit & d_val;
        do_oe   <= d_hit;
      end
    end
  end

  // R12: serial outputs hold between rising bit-clock edges
  assert_out_stable_R12: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable({bo, bo_oe, tsb_n, do_data, do_oe}));
  // R5: the busy strobe is asserted whenever bo is driven
  assert_busy_with_bo_R5: assert property (@(posedge clk) disable iff (rst)
    bo_oe |-> !tsb_n);
  // R3: a bearer slot only opens right after a rising edge
  assert_bo_open_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bo_oe) |-> $past(rise));
  // R6: a signalling sub-slot only opens right after a rising edge
  assert_do_open_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(do_oe) |-> $past(rise));
endmodule

// File: rtl/tsa_backplane_port.sv
module tsa_backplane_port
  import tsa_pkg::*;
#(
  parameter int NL        = 4,
  parameter int NUM_SLOTS = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bclk,
  input  logic                        fs,
  input  logic                        bi,
  input  logic                        di,
  output logic                        bo,
  output logic                        bo_oe,
  output logic                        tsb_n,
  output logic                        do_data,
  output logic                        do_oe,
  input  logic                        wr_en,
  input  logic [$clog2(NL)-1:0]       wr_line,
  input  logic [2:0]                  wr_sel,
  input  logic [7:0]                  wr_data,
  input  logic [NL*BYTE_BITS-1:0]     rx_b1,
  input  logic [NL*BYTE_BITS-1:0]     rx_b2,
  input  logic [NL*SUB_BITS-1:0]      rx_d,
  output logic [NL*BYTE_BITS-1:0]     tx_b1,
  output logic [NL*BYTE_BITS-1:0]     tx_b2,
  output logic [NL*SUB_BITS-1:0]      tx_d,
  output logic                        tx_stb
);
  localparam int LW     = $clog2(NL);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int POS_W  = SLOT_W + 3;

  logic [NL-1:0][7:0] txb1, txb2, txd, rxb1, rxb2, rxd;
  logic [NL-1:0]      txd_en, rxd_en;
  logic               rise, fall, frame_start;
  logic [POS_W-1:0]   pos, next_pos;

  logic [NL-1:0][BYTE_BITS-1:0] in_b1, in_b2, o_b1, o_b2;
  logic [NL-1:0][SUB_BITS-1:0]  in_d, o_d;

  assign in_b1 = rx_b1;
  assign in_b2 = rx_b2;
  assign in_d  = rx_d;
  assign tx_b1 = o_b1;
  assign tx_b2 = o_b2;
  assign tx_d  = o_d;

  tsa_regs #(.NL(NL), .LW(LW)) u_regs (
    .clk, .rst, .wr_en, .wr_line, .wr_sel, .wr_data,
    .txb1, .txb2, .txd, .rxb1, .rxb2, .rxd, .txd_en, .rxd_en
  );

  tsa_frame_cnt #(.POS_W(POS_W)) u_cnt (
    .clk, .rst, .bclk, .fs, .rise, .fall, .frame_start, .pos, .next_pos
  );

  tsa_tx_capture #(.NL(NL), .SLOT_W(SLOT_W), .POS_W(POS_W)) u_tx (
    .clk, .rst, .fall, .frame_start, .pos, .bi, .di,
    .txb1, .txb2, .txd, .txd_en,
    .out_b1(o_b1), .out_b2(o_b2), .out_d(o_d), .stb(tx_stb)
  );

  tsa_rx_drive #(.NL(NL), .SLOT_W(SLOT_W), .POS_W(POS_W)) u_rx (
    .clk, .rst, .rise, .frame_start, .next_pos,
    .rxb1, .rxb2, .rxd, .rxd_en, .in_b1, .in_b2, .in_d,
    .bo, .bo_oe, .tsb_n, .do_data, .do_oe
  );
endmodule

// File: tb/tb_tsa_backplane_port.sv
module tb_tsa_backplane_port;
  localparam int NL = 4;
  localparam int FRAME_BITS = 512;

  logic clk = 0, rst = 1, bclk = 0, fs = 0, bi = 0, di = 0;
  logic wr_en = 0;
  logic [1:0] wr_line = 0;
  logic [2:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [NL*8-1:0] rx_b1 = '0, rx_b2 = '0;
  logic [NL*2-1:0] rx_d = '0;
  logic bo, bo_oe, tsb_n, do_data, do_oe, tx_stb;
  logic [NL*8-1:0] tx_b1, tx_b2;
  logic [NL*2-1:0] tx_d;

  int n_chk = 0, n_err = 0, stb_cnt = 0, frames = 0;
  bit done = 0;

  logic [7:0] c_txb1[NL], c_txb2[NL], c_txd[NL], c_rxb1[NL], c_rxb2[NL], c_rxd[NL];
  bit         c_txden[NL], c_rxden[NL];
  logic [7:0] f_rxb1[NL], f_rxb2[NL], cap_b1[NL], cap_b2[NL];
  logic [1:0] f_rxd[NL], cap_d[NL];

  tsa_backplane_port dut (
    .clk, .rst, .bclk, .fs, .bi, .di, .bo, .bo_oe, .tsb_n, .do_data, .do_oe,
    .wr_en, .wr_line, .wr_sel, .wr_data, .rx_b1, .rx_b2, .rx_d,
    .tx_b1, .tx_b2, .tx_d, .tx_stb
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (!rst && tx_stb) stb_cnt <= stb_cnt + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] src_byte(input int slot, input int seed);
    return 8'((slot * 29 + seed * 71 + 90) & 255);
  endfunction

  function automatic logic [1:0] src_d(input int sub, input int seed);
    return 2'((sub * 3 + seed) & 3);
  endfunction

  task automatic wr(input int line, input int sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_line = 2'(line); wr_sel = 3'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (sel)
      0: c_txb1[line] = d;
      1: c_txb2[line] = d;
      2: c_txd[line]  = d;
      3: c_rxb1[line] = d;
      4: c_rxb2[line] = d;
      5: c_rxd[line]  = d;
      6: begin c_txden[line] = d[0]; c_rxden[line] = d[1]; end
      default: ;
    endcase
  endtask

  // Runs one frame of nbits bit periods; predicts every serial output bit.
  task automatic run_frame(input int seed, input int nbits, input int mid_bit);
    for (int l = 0; l < NL; l++) begin
      f_rxb1[l] = rx_b1[l*8 +: 8];
      f_rxb2[l] = rx_b2[l*8 +: 8];
      f_rxd[l]  = rx_d[l*2 +: 2];
    end
    for (int p = 0; p < nbits; p++) begin
      logic [7:0] sb;
      logic [1:0] sd;
      bit bh, dh;
      logic bv, dv;
      sb = src_byte(p / 8, seed);
      sd = src_d(p / 2, seed);
      @(negedge clk);
      bclk = 1; fs = (p == 0); bi = sb[7 - (p % 8)]; di = sd[1 - (p % 2)];
      @(negedge clk);
      bh = 0; bv = 0; dh = 0; dv = 0;
      for (int l = 0; l < NL; l++) begin
        if (!bh && c_rxb1[l][7] && int'(c_rxb1[l][5:0]) == p / 8) begin
          bh = 1; bv = f_rxb1[l][7 - (p % 8)];
        end
        if (!bh && c_rxb2[l][7] && int'(c_rxb2[l][5:0]) == p / 8) begin
          bh = 1; bv = f_rxb2[l][7 - (p % 8)];
        end
        if (!dh && c_rxden[l] && int'(c_rxd[l]) == p / 2) begin
          dh = 1; dv = f_rxd[l][1 - (p % 2)];
        end
      end
      chk(bo_oe == bh, "R3/R2", $sformatf("bo_oe pos %0d", p), bo_oe, bh);
      chk(tsb_n == !bh, "R5", $sformatf("tsb_n pos %0d", p), tsb_n, !bh);
      if (bh) chk(bo == bv, "R3/R10/R11", $sformatf("bo pos %0d", p), bo, bv);
      chk(do_oe == dh, "R6", $sformatf("do_oe pos %0d", p), do_oe, dh);
      if (dh) chk(do_data == dv, "R6/R10/R11", $sformatf("do pos %0d", p), do_data, dv);
      if (p == 0) begin
        for (int l = 0; l < NL; l++) begin
          logic [7:0] e1, e2;
          logic [1:0] ed;
          e1 = c_txb1[l][7] ? cap_b1[l] : 8'hFF;
          e2 = c_txb2[l][7] ? cap_b2[l] : 8'hFF;
          ed = c_txden[l] ? cap_d[l] : 2'b11;
          chk(tx_b1[l*8 +: 8] == e1, "R7/R8", $sformatf("tx_b1 line %0d", l), tx_b1[l*8 +: 8], e1);
          chk(tx_b2[l*8 +: 8] == e2, "R7/R8", $sformatf("tx_b2 line %0d", l), tx_b2[l*8 +: 8], e2);
          chk(tx_d[l*2 +: 2] == ed, "R9/R8", $sformatf("tx_d line %0d", l), tx_d[l*2 +: 2], ed);
        end
      end
      if (p == mid_bit) begin
        rx_b1 = ~rx_b1; rx_b2 = ~rx_b2; rx_d = ~rx_d;
      end
      @(negedge clk);
      bclk = 0; fs = 0;
      @(negedge clk);
      if (p == 0) begin
        frames++;
        chk(stb_cnt == frames, "R7", "tx_stb pulse count", stb_cnt, frames);
      end
    end
    for (int l = 0; l < NL; l++) begin
      if (c_txb1[l][7] && int'(c_txb1[l][5:0]) * 8 + 7 < nbits)
        cap_b1[l] = src_byte(int'(c_txb1[l][5:0]), seed);
      if (c_txb2[l][7] && int'(c_txb2[l][5:0]) * 8 + 7 < nbits)
        cap_b2[l] = src_byte(int'(c_txb2[l][5:0]), seed);
      if (c_txden[l] && int'(c_txd[l]) * 2 + 1 < nbits)
        cap_d[l] = src_d(int'(c_txd[l]), seed);
    end
  endtask

  task automatic t_reset;
    chk(bo_oe == 0, "R1", "bo_oe after reset", bo_oe, 0);
    chk(tsb_n == 1, "R1", "tsb_n after reset", tsb_n, 1);
    chk(do_oe == 0, "R1", "do_oe after reset", do_oe, 0);
    chk(tx_stb == 0, "R1", "tx_stb after reset", tx_stb, 0);
    chk(tx_b1 == '1 && tx_b2 == '1, "R1", "tx bytes after reset", tx_b1[7:0], 8'hFF);
    chk(tx_d == '1, "R1", "tx_d after reset", tx_d, 8'hFF);
    wr(0, 7, 8'hFF);  // ignored select code
    run_frame(0, FRAME_BITS, -1);  // nothing may be driven
  endtask

  task automatic t_b_receive;
    rx_b1 = 32'hA5_3C_81_C6; rx_b2 = 32'h5A_E7_19_0F;
    wr(0, 3, 8'h83);  // line0 rx B1 slot 3
    wr(2, 4, 8'hBF);  // line2 rx B2 slot 63 (R4 boundary)
    wr(1, 3, 8'hC5);  // line1 rx B1 slot 5 with bit 6 set (R4)
    wr(3, 4, 8'h07);  // line3 rx B2 slot 7 but disabled (R3)
    run_frame(1, FRAME_BITS, -1);
  endtask

  task automatic t_d_receive;
    rx_d = 8'b10_01_11_10;
    wr(1, 5, 8'd0);   wr(1, 6, 8'h02);   // line1 rx D sub-slot 0
    wr(3, 5, 8'd255); wr(3, 6, 8'h02);   // line3 rx D sub-slot 255
    wr(0, 5, 8'd40);                     // line0 sub-slot set but not enabled
    run_frame(2, FRAME_BITS, -1);
  endtask

  task automatic t_realign;  // R2: an early fs restarts the count
    run_frame(3, 37, -1);
    run_frame(4, FRAME_BITS, -1);
  endtask

  task automatic t_priority;  // R10
    wr(1, 3, 8'h8A); wr(1, 4, 8'h8A); wr(2, 3, 8'h8A);
    wr(2, 4, 8'h8C); wr(3, 3, 8'h8C);
    wr(2, 5, 8'd255); wr(2, 6, 8'h02);
    run_frame(5, FRAME_BITS, -1);
  endtask

  task automatic t_latch;  // R11: mid-frame input changes wait a frame
    run_frame(6, FRAME_BITS, 20);
    run_frame(7, FRAME_BITS, -1);
  endtask

  task automatic t_transmit;  // R7, R8, R9
    wr(0, 0, 8'h82); wr(0, 1, 8'h82);
    wr(1, 0, 8'hE8);                    // slot 40, bit 6 ignored
    wr(3, 1, 8'hBF);                    // slot 63
    wr(2, 2, 8'd17);  wr(2, 6, 8'h01);
    wr(0, 2, 8'd255); wr(0, 6, 8'h01);
    run_frame(11, FRAME_BITS, -1);
    run_frame(12, FRAME_BITS, -1);
    wr(1, 0, 8'h28);                    // disable line1 tx B1 (R8)
    wr(2, 6, 8'h00);                    // disable line2 tx D (R8)
    run_frame(13, FRAME_BITS, -1);
    run_frame(14, FRAME_BITS, -1);
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin
      c_txb1[l] = 0; c_txb2[l] = 0; c_txd[l] = 0;
      c_rxb1[l] = 0; c_rxb2[l] = 0; c_rxd[l] = 0;
      c_txden[l] = 0; c_rxden[l] = 0;
      cap_b1[l] = 0; cap_b2[l] = 0; cap_d[l] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_b_receive();
    t_d_receive();
    t_realign();
    t_priority();
    t_latch();
    t_transmit();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule